// File: doc/BRIEF.md
# Descriptor-Ring Transmit DMA Engine

This block moves outgoing packets from system memory to a byte stream. Software builds a ring of four-word descriptors in memory. For each packet it hands the descriptor to hardware by clearing the descriptor's done flag. It then advances a CPU index register, which acts as the doorbell. While the engine's own DMA index trails the CPU index, the engine works through the descriptors one at a time. For each one it reads the length word and then the buffer pointer, fetches the buffer a 32-bit word at a time, and sends the bytes out on a valid/ready stream. When the packet is finished it can write the descriptor back with the done flag set, which returns ownership to software.

A small register port holds the ring base, the ring count, both indices, an index reset and a control/status word. The control/status word carries enable, busy, done write-back and a sticky error flag. A simple request/acknowledge memory master port carries all descriptor and buffer traffic. Software stops the engine by clearing enable and then polling busy.

Top module: `txdma_ring_engine`

## Requirements
- R1: After reset every register reads zero, busy is low, and the block makes no memory request and no stream transfer.
- R2: While enable is set, the error flag is clear and the DMA index differs from the CPU index, the engine processes descriptor `idx` at `base + 16*idx`. It reads the length word at offset 4 and then the buffer pointer at offset 0. When the descriptor is complete the DMA index advances by one, and it wraps to 0 when it reaches the ring count. A memory request holds its address and write flag until it is acknowledged.
- R3: The length field (bits 29:16 of the word at offset 4) gives the byte count. The buffer pointer must be word-aligned. Bytes leave in address order, with the lowest byte of each 32-bit word first. Data and last are held while valid is high and ready is low.
- R4: `tx_last_o` is high on the final byte of each packet and on no other byte.
- R5: When write-back (control bit 6) is set, a finished descriptor's word at offset 4 is rewritten with bit 31 (done) set and every other bit unchanged. When bit 6 is clear, no write is made.
- R6: A descriptor with length zero sends no bytes and makes no buffer or pointer read. It still completes: write-back as in R5, then the index advance.
- R7: Clearing enable (control bit 0) during a packet lets that packet finish, including write-back and the index advance. Busy (control bit 1) then falls and no further descriptor is fetched.
- R8: Writing 1 to bit 0 of the index-reset register sets the DMA index to 0.
- R9: An error response on any memory access sets the sticky error flag (control bit 8). Busy falls, the DMA index is not advanced and no further request is made. Writing 1 to control bit 8 clears the flag, and pending work then resumes.
- R10: The register word addresses are: 0 base, 1 ring count, 2 CPU index, 3 DMA index (read-only), 4 control/status, 5 index reset. Written values read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle |
| mem_err_i | input | 1 | Error response, valid with acknowledge |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |
| tx_data_o | output | 8 | Stream byte |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_last_o | output | 1 | Final byte of packet |
| tx_ready_i | input | 1 | Stream sink ready |

## Verification
The hardest case to reach from the ports is clearing enable while a packet is partly streamed with a second descriptor already pending. The bench rings the doorbell two entries ahead using a 40-byte first packet and holds ready low one cycle in three, so the stream is slow. It waits until valid is seen and only then clears enable. A memory error in the middle of a descriptor is the other hard case. The bench memory model answers one chosen buffer address with an error response. It then checks that the index is frozen and that the request count stays the same until the flag is cleared.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_LEN, ST_RD_PTR, ST_RD_BUF, ST_STREAM, ST_WB, ST_ADV
  } walk_st_e;

  localparam logic [2:0] RA_BASE = 3'd0;
  localparam logic [2:0] RA_CNT  = 3'd1;
  localparam logic [2:0] RA_CPU  = 3'd2;
  localparam logic [2:0] RA_DMA  = 3'd3;
  localparam logic [2:0] RA_CTRL = 3'd4;
  localparam logic [2:0] RA_IRST = 3'd5;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_BUSY = 1;
  localparam int CTRL_WB   = 6;
  localparam int CTRL_ERR  = 8;

  localparam int LEN_LSB = 16;
  localparam int LEN_W   = 14;
endpackage

// File: rtl/txdma_regs.sv
module txdma_regs
  import txdma_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [IDX_W-1:0] dma_idx_i,
  input  logic             busy_i,
  input  logic             err_set_i,
  output logic [31:0]      base_o,
  output logic [IDX_W:0]   cnt_o,
  output logic [IDX_W-1:0] cpu_idx_o,
  output logic             en_o,
  output logic             wb_en_o,
  output logic             err_o,
  output logic             idx_rst_o
);
  logic wr_ctrl;
  assign wr_ctrl   = we_i && (addr_i == RA_CTRL);
  assign idx_rst_o = we_i && (addr_i == RA_IRST) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o    <= '0;
      cnt_o     <= '0;
      cpu_idx_o <= '0;
      en_o      <= 1'b0;
      wb_en_o   <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      if (we_i && addr_i == RA_BASE) base_o    <= wdata_i;
      if (we_i && addr_i == RA_CNT)  cnt_o     <= wdata_i[IDX_W:0];
      if (we_i && addr_i == RA_CPU)  cpu_idx_o <= wdata_i[IDX_W-1:0];
      if (wr_ctrl) begin
        en_o    <= wdata_i[CTRL_EN];
        wb_en_o <= wdata_i[CTRL_WB];
      end
      if (err_set_i)                       err_o <= 1'b1;
      else if (wr_ctrl && wdata_i[CTRL_ERR]) err_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_BASE: rdata_o = base_o;
      RA_CNT:  rdata_o = 32'(cnt_o);
      RA_CPU:  rdata_o = 32'(cpu_idx_o);
      RA_DMA:  rdata_o = 32'(dma_idx_i);
      RA_CTRL: begin
        rdata_o[CTRL_EN]   = en_o;
        rdata_o[CTRL_BUSY] = busy_i;
        rdata_o[CTRL_WB]   = wb_en_o;
        rdata_o[CTRL_ERR]  = err_o;
      end
      default: rdata_o = '0;
    endcase
  end

  AST_ERR_FROM_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(err_set_i)); // R9
endmodule

// File: rtl/txdma_serializer.sv
module txdma_serializer (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [31:0] word_i,
  input  logic [2:0]  nbytes_i,
  input  logic        last_i,
  output logic        empty_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_valid_o,
  output logic        tx_last_o,
  input  logic        tx_ready_i
);
  logic [31:0] word_q;
  logic [2:0]  cnt_q;
  logic        last_q;

  assign empty_o    = (cnt_q == 3'd0);
  assign tx_valid_o = !empty_o;
  assign tx_data_o  = word_q[7:0];
  assign tx_last_o  = last_q && (cnt_q == 3'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (load_i) begin
      word_q <= word_i;
      cnt_q  <= nbytes_i;
      last_q <= last_i;
    end else if (tx_valid_o && tx_ready_i) begin
      word_q <= word_q >> 8;
      cnt_q  <= cnt_q - 3'd1;
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)); // R3
  AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> empty_o); // R3
endmodule

// File: rtl/txdma_walker.sv
module txdma_walker
  import txdma_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             err_i,
  input  logic             wb_en_i,
  input  logic [31:0]      base_i,
  input  logic [IDX_W:0]   cnt_i,
  input  logic [IDX_W-1:0] cpu_idx_i,
  input  logic             idx_rst_i,
  output logic [IDX_W-1:0] dma_idx_o,
  output logic             busy_o,
  output logic             err_set_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [31:0]      mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic             mem_err_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             ser_load_o,
  output logic [31:0]      ser_word_o,
  output logic [2:0]       ser_nbytes_o,
  output logic             ser_last_o,
  input  logic             ser_empty_i
);
  localparam int PAD_W = 32 - IDX_W - 4;

  walk_st_e         state_q;
  logic [31:0]      len_word_q;
  logic [31:0]      buf_q;
  logic [LEN_W-1:0] rem_q;
  logic [IDX_W-1:0] idx_q;

  logic [31:0]      desc_addr;
  logic [IDX_W:0]   idx_inc;
  logic [IDX_W-1:0] idx_next;
  logic [LEN_W-1:0] new_len;
  logic             ack_ok;
  walk_st_e         done_st;

  assign desc_addr = base_i + {{PAD_W{1'b0}}, idx_q, 4'b0000};
  assign idx_inc   = {1'b0, idx_q} + 1'b1;
  assign idx_next  = (idx_inc >= cnt_i) ? '0 : idx_inc[IDX_W-1:0];
  assign new_len   = mem_rdata_i[LEN_LSB +: LEN_W];
  assign ack_ok    = mem_ack_i && !mem_err_i;
  assign done_st   = wb_en_i ? ST_WB : ST_ADV;

  assign dma_idx_o = idx_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign mem_req_o = (state_q == ST_RD_LEN) || (state_q == ST_RD_PTR) ||
                     (state_q == ST_RD_BUF) || (state_q == ST_WB);
  assign mem_we_o  = (state_q == ST_WB);
  assign mem_wdata_o = {1'b1, len_word_q[30:0]};
  assign err_set_o = mem_req_o && mem_ack_i && mem_err_i;

  always_comb begin
    case (state_q)
      ST_RD_PTR: mem_addr_o = desc_addr;
      ST_RD_BUF: mem_addr_o = buf_q;
      default:   mem_addr_o = desc_addr + 32'd4;
    endcase
  end

  assign ser_load_o   = (state_q == ST_RD_BUF) && ack_ok;
  assign ser_word_o   = mem_rdata_i;
  assign ser_nbytes_o = (rem_q >= LEN_W'(4)) ? 3'd4 : rem_q[2:0];
  assign ser_last_o   = (rem_q <= LEN_W'(4));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   idx_q <= '0;
    else if (idx_rst_i)            idx_q <= '0;
    else if (state_q == ST_ADV)    idx_q <= idx_next;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      len_word_q <= '0;
      buf_q      <= '0;
      rem_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE:
          if (en_i && !err_i && (idx_q != cpu_idx_i)) state_q <= ST_RD_LEN;
        ST_RD_LEN:
          if (mem_ack_i) begin
            if (mem_err_i) state_q <= ST_IDLE;
            else begin
              len_word_q <= mem_rdata_i;
              rem_q      <= new_len;
              state_q    <= (new_len == '0) ? done_st : ST_RD_PTR;
            end
          end
        ST_RD_PTR:
          if (mem_ack_i) begin
            if (mem_err_i) state_q <= ST_IDLE;
            else begin
              buf_q   <= mem_rdata_i;
              state_q <= ST_RD_BUF;
            end
          end
        ST_RD_BUF:
          if (mem_ack_i) begin
            if (mem_err_i) state_q <= ST_IDLE;
            else begin
              rem_q   <= rem_q - LEN_W'(ser_nbytes_o);
              buf_q   <= buf_q + 32'd4;
              state_q <= ST_STREAM;
            end
          end
        ST_STREAM:
          if (ser_empty_i) state_q <= (rem_q == '0) ? done_st : ST_RD_BUF;
        ST_WB:
          if (mem_ack_i) state_q <= mem_err_i ? ST_IDLE : ST_ADV;
        ST_ADV:
          state_q <= ST_IDLE;
        default:
          state_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i && !idx_rst_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R2
  AST_ERR_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set_o |=> !busy_o); // R9
  AST_WB_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[31] && wb_en_i); // R5
endmodule

// File: rtl/txdma_ring_engine.sv
module txdma_ring_engine #(
  parameter int IDX_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_ack_i,
  input  logic        mem_err_i,
  input  logic [31:0] mem_rdata_i,
  output logic [7:0]  tx_data_o,
  output logic        tx_valid_o,
  output logic        tx_last_o,
  input  logic        tx_ready_i
);
  logic [31:0]      base;
  logic [IDX_W:0]   cnt;
  logic [IDX_W-1:0] cpu_idx, dma_idx;
  logic             en, wb_en, err, idx_rst, busy, err_set;
  logic             ser_load, ser_last, ser_empty;
  logic [31:0]      ser_word;
  logic [2:0]       ser_nbytes;

  txdma_regs #(.IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .dma_idx_i(dma_idx), .busy_i(busy), .err_set_i(err_set),
    .base_o(base), .cnt_o(cnt), .cpu_idx_o(cpu_idx),
    .en_o(en), .wb_en_o(wb_en), .err_o(err), .idx_rst_o(idx_rst)
  );

  txdma_walker #(.IDX_W(IDX_W)) u_walker (
    .clk_i, .rst_ni,
    .en_i(en), .err_i(err), .wb_en_i(wb_en), .base_i(base), .cnt_i(cnt),
    .cpu_idx_i(cpu_idx), .idx_rst_i(idx_rst),
    .dma_idx_o(dma_idx), .busy_o(busy), .err_set_o(err_set),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_ack_i, .mem_err_i, .mem_rdata_i,
    .ser_load_o(ser_load), .ser_word_o(ser_word), .ser_nbytes_o(ser_nbytes),
    .ser_last_o(ser_last), .ser_empty_i(ser_empty)
  );

  txdma_serializer u_ser (
    .clk_i, .rst_ni,
    .load_i(ser_load), .word_i(ser_word), .nbytes_i(ser_nbytes), .last_i(ser_last),
    .empty_o(ser_empty),
    .tx_data_o, .tx_valid_o, .tx_last_o, .tx_ready_i
  );

  AST_NO_REQ_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mem_req_o && !tx_valid_o); // R7
endmodule

// File: tb/txdma_ring_engine_tb.sv
`timescale 1ns/1ps
module txdma_ring_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, tx_ready;

  always #2.5 clk = ~clk;

  txdma_ring_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_err_i(mem_err), .mem_rdata_i(mem_rdata),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_last_o(tx_last), .tx_ready_i(tx_ready)
  );

  localparam logic [31:0] BASE = 32'h40;
  localparam logic [31:0] BUF0 = 32'h100;

  // memory model: one-cycle-later acknowledge, host port for bench writes
  logic [31:0] mem [0:255];
  logic        hw_we = 1'b0;
  logic [7:0]  hw_a = '0;
  logic [31:0] hw_d = '0;
  logic        err_on = 1'b0;
  logic [31:0] err_addr = '0;
  int          req_cnt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_err   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        req_cnt   <= req_cnt + 1;
        mem_rdata <= mem[mem_addr[9:2]];
        mem_err   <= err_on && (mem_addr == err_addr);
        if (mem_we && !(err_on && mem_addr == err_addr)) mem[mem_addr[9:2]] <= mem_wdata;
      end
      if (hw_we) mem[hw_a] <= hw_d;
    end
  end

  logic [7:0] rcnt = '0;
  always @(negedge clk) rcnt <= rcnt + 8'd1;
  assign tx_ready = (rcnt % 3) != 2;

  logic [7:0] cap_data [0:255];
  logic       cap_last [0:255];
  int         cap_n = 0;
  always @(posedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      cap_data[cap_n[7:0]] <= tx_data;
      cap_last[cap_n[7:0]] <= tx_last;
      cap_n <= cap_n + 1;
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #0.5 v = reg_rdata;
  endtask

  task automatic hwr(input logic [31:0] byte_addr, input logic [31:0] d);
    @(negedge clk); hw_we = 1'b1; hw_a = byte_addr[9:2]; hw_d = d;
    @(negedge clk); hw_we = 1'b0;
  endtask

  function automatic logic [31:0] len_word(input int len);
    return {1'b0, 1'b1, 14'(len), 16'h00A5};
  endfunction

  task automatic prep(input int idx, input int len, input logic [7:0] seed);
    logic [31:0] bufa, w;
    bufa = BUF0 + 32'(idx) * 32'h40;
    hwr(BASE + 32'(idx) * 16, bufa);
    hwr(BASE + 32'(idx) * 16 + 4, len_word(len));
    for (int k = 0; k < (len + 3) / 4; k++) begin
      for (int b = 0; b < 4; b++) w[8*b +: 8] = seed + 8'(4*k + b);
      hwr(bufa + 32'(4*k), w);
    end
  endtask

  task automatic wait_idle(input int target);
    logic [31:0] c, d;
    int t;
    repeat (4) @(negedge clk);
    t = 0;
    rd(3'd4, c); rd(3'd3, d);
    while ((c[1] || d != 32'(target)) && t < 3000) begin
      rd(3'd4, c); rd(3'd3, d); t++;
    end
  endtask

  task automatic check_pkt(input string req, input int cap0, input int len, input logic [7:0] seed);
    chk({req, " byte count"}, 32'(cap_n - cap0), 32'(len));
    for (int k = 0; k < len && k < cap_n - cap0; k++) begin
      chk({req, " data"}, 32'(cap_data[8'(cap0 + k)]), 32'(seed + 8'(k)));
      chk("R4 last flag", 32'(cap_last[8'(cap0 + k)]), 32'(k == len - 1));
    end
  endtask

  localparam int NV = 6;
  localparam logic [21:0] VEC [NV] = '{
    {14'd1, 8'h10}, {14'd3, 8'h20}, {14'd4, 8'h30},
    {14'd5, 8'h40}, {14'd8, 8'h50}, {14'd13, 8'h60}
  };

  initial begin
    logic [31:0] v;
    int cap0, r0, len;
    logic [7:0] seed;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk("R1 reg reset", v, 32'h0);
    end
    chk("R1 no req", 32'(mem_req), 32'h0);
    chk("R1 no valid", 32'(tx_valid), 32'h0);

    // R10 register map
    wr(3'd0, BASE); wr(3'd1, 32'd4); wr(3'd4, 32'h41);
    rd(3'd0, v); chk("R10 base", v, BASE);
    rd(3'd1, v); chk("R10 count", v, 32'd4);
    rd(3'd4, v); chk("R10 ctrl", v, 32'h41);

    // R2 R3 R4 R5: vector table across the ring wrap
    for (int i = 0; i < NV; i++) begin
      len = int'(VEC[i][21:8]); seed = VEC[i][7:0];
      prep(i % 4, len, seed);
      cap0 = cap_n;
      wr(3'd2, 32'((i + 1) % 4));
      wait_idle((i + 1) % 4);
      check_pkt("R3", cap0, len, seed);
      rd(3'd3, v); chk("R2 dma index", v, 32'((i + 1) % 4));
      chk("R5 done writeback", mem[(BASE >> 2) + 32'((i % 4) * 4 + 1)], {1'b1, len_word(len)[30:0]});
    end

    // R6 zero length at index 2
    prep(2, 0, 8'h00);
    cap0 = cap_n; r0 = req_cnt;
    wr(3'd2, 32'd3); wait_idle(3);
    chk("R6 no bytes", 32'(cap_n - cap0), 32'd0);
    chk("R6 only len read and writeback", 32'(req_cnt - r0), 32'd2);
    chk("R6 done set", mem[(BASE >> 2) + 9], {1'b1, len_word(0)[30:0]});

    // R5 write-back disabled at index 3
    wr(3'd4, 32'h01);
    prep(3, 3, 8'h70);
    cap0 = cap_n;
    wr(3'd2, 32'd0); wait_idle(0);
    check_pkt("R5", cap0, 3, 8'h70);
    chk("R5 no writeback", mem[(BASE >> 2) + 13], len_word(3));

    // R7 stop during a packet with a second one pending
    wr(3'd4, 32'h41);
    prep(0, 40, 8'h80); prep(1, 5, 8'hC0);
    cap0 = cap_n;
    wr(3'd2, 32'd2);
    for (int t = 0; t < 500 && !tx_valid; t++) @(negedge clk);
    wr(3'd4, 32'h40);
    wait_idle(1);
    check_pkt("R7", cap0, 40, 8'h80);
    r0 = req_cnt;
    repeat (20) @(negedge clk);
    rd(3'd4, v); chk("R7 busy low", 32'(v[1]), 32'd0);
    rd(3'd3, v); chk("R7 index held", v, 32'd1);
    chk("R7 no fetch", 32'(req_cnt - r0), 32'd0);

    // R8 index reset
    wr(3'd2, 32'd0); wr(3'd5, 32'd1);
    rd(3'd3, v); chk("R8 dma index zero", v, 32'd0);

    // R9 memory error on the buffer read
    prep(0, 6, 8'hD0);
    err_addr = BUF0; err_on = 1'b1;
    wr(3'd4, 32'h41);
    cap0 = cap_n;
    wr(3'd2, 32'd1);
    v = '0;
    for (int t = 0; t < 300 && !v[8]; t++) rd(3'd4, v);
    chk("R9 error flag", 32'(v[8]), 32'd1);
    r0 = req_cnt;
    repeat (15) @(negedge clk);
    rd(3'd4, v); chk("R9 busy low", 32'(v[1]), 32'd0);
    rd(3'd3, v); chk("R9 index frozen", v, 32'd0);
    chk("R9 no requests", 32'(req_cnt - r0), 32'd0);
    chk("R9 no bytes", 32'(cap_n - cap0), 32'd0);
    err_on = 1'b0;
    wr(3'd4, 32'h141);
    wait_idle(1);
    rd(3'd4, v); chk("R9 flag cleared", 32'(v[8]), 32'd0);
    check_pkt("R9 resume", cap0, 6, 8'hD0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog all requirements act=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule